// File: doc/BRIEF.md
# Requester-ID to Partition Mapper

This block keeps a small programmable table that assigns PCIe requester IDs to partitionable-endpoint (PE) numbers. Each PE number owns exactly one slot. A slot holds:

- a base bus, device and function;
- a code that says how many high-order bus bits take part in the match;
- two enables that switch the device and function comparisons on or off;
- a valid bit.

Because parts of the ID can be left out of the comparison, a single slot can claim a whole range of requesters.

Software-side logic programs the table through a one-cycle configuration strobe. The strobe carries the PE number, the base ID, the compare controls and an action (map or unmap). A malformed write is refused, and a one-cycle error pulse is raised.

The datapath presents a 16-bit requester ID on the lookup port. One clock later it receives a hit flag and the PE number of the matching slot. When several slots match, the one with the lowest PE number wins.

Top module: `rid_pe_mapper`

## Requirements
- R1: After reset every slot is invalid, so lookups miss with PE output 0; `cfg_err_o` and `lk_valid_o` are low.
- R2: A requester ID is split as bus = bits 15:8, device = bits 7:3, function = bits 2:0, and each is compared against the slot's base fields of the same positions.
- R3: Bus code 0 accepts any bus number.
- R4: Bus codes 2 to 6 compare only the top (code+1) bits of the bus number.
- R5: Bus code 7 compares all eight bus bits.
- R6: With the device enable at 0 any device number is accepted. With it at 1 the device number must equal the base.
- R7: With the function enable at 0 any function number is accepted. With it at 1 the function number must equal the base.
- R8: Action 1 loads the slot and marks it valid. Action 0 marks it invalid. Actions 2 and 3 are refused: the table is unchanged and `cfg_err_o` pulses.
- R9: A write with a PE number of `NUM_PE` or more, or with bus code 1, is refused: the table is unchanged and `cfg_err_o` is high in the cycle after the strobe. A write that is accepted leaves it low.
- R10: When several valid slots match, the lowest PE number is reported. A miss reports `lk_hit_o` = 0 and `lk_pe_o` = 0.
- R11: Lookup results appear one cycle after `lk_valid_i`. `lk_valid_o` is `lk_valid_i` delayed by one cycle, and the lookup sees the table as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_valid_i | input | 1 | Configuration write strobe |
| cfg_pe_i | input | PE_IN_W (8) | Target PE number |
| cfg_rid_i | input | 16 | Base requester ID (bus/device/function) |
| cfg_bus_code_i | input | 3 | Bus compare code |
| cfg_dev_en_i | input | 1 | Device compare enable |
| cfg_fn_en_i | input | 1 | Function compare enable |
| cfg_action_i | input | 2 | 0 unmap, 1 map, others refused |
| cfg_err_o | output | 1 | Refused-write pulse, one cycle after the strobe |
| lk_valid_i | input | 1 | Lookup request |
| lk_rid_i | input | 16 | Requester ID to look up |
| lk_valid_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | A valid slot matched |
| lk_pe_o | output | PE_W (4) | Matching PE number, lowest wins |

## Verification
The assertions assume that all configuration and lookup inputs are free of unknowns whenever their strobe is high. They also assume that the strobes themselves are never unknown once reset has been released. The bench keeps to this:

- it changes inputs only on the falling clock edge;
- it returns every field to a defined value when a strobe drops;
- it holds reset for several cycles so the internal synchronizer settles before the first request.

Refused writes are sent with otherwise well-formed fields, so that any change in the table can only come from a write that should have been blocked.

// File: rtl/rid_map_pkg.sv
package rid_map_pkg;

  localparam int RID_W = 16;

  localparam logic [1:0] ACT_UNMAP = 2'd0;
  localparam logic [1:0] ACT_MAP   = 2'd1;

  typedef struct packed {
    logic       vld;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [2:0] bus_code;
    logic       dev_en;
    logic       fn_en;
  } rid_slot_t;

  // Which bus bits take part in the compare for a given code.
  function automatic logic [7:0] bus_mask(input logic [2:0] code);
    logic [7:0] m;
    case (code)
      3'd0:    m = 8'h00;
      3'd7:    m = 8'hFF;
      default: m = 8'hFF << (3'd7 - code);
    endcase
    return m;
  endfunction

endpackage

// File: rtl/rid_map_cfg.sv
module rid_map_cfg
  import rid_map_pkg::*;
#(
  parameter int NUM_PE  = 12,
  parameter int PE_IN_W = 8,
  parameter int PE_W    = $clog2(NUM_PE)
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               cfg_valid_i,
  input  logic [PE_IN_W-1:0] cfg_pe_i,
  input  logic [RID_W-1:0]   cfg_rid_i,
  input  logic [2:0]         cfg_bus_code_i,
  input  logic               cfg_dev_en_i,
  input  logic               cfg_fn_en_i,
  input  logic [1:0]         cfg_action_i,
  output logic               wr_en_o,
  output logic               wr_map_o,
  output logic [PE_W-1:0]    wr_pe_o,
  output rid_slot_t          wr_slot_o,
  output logic               err_o
);

  logic pe_bad, code_bad, act_bad, reject;
  logic err_d, err_q;

  always_comb begin
    pe_bad   = (cfg_pe_i >= PE_IN_W'(NUM_PE));
    code_bad = (cfg_bus_code_i == 3'd1);
    act_bad  = (cfg_action_i != ACT_UNMAP) && (cfg_action_i != ACT_MAP);
    reject   = pe_bad || code_bad || act_bad;
  end

  always_comb begin
    wr_en_o            = cfg_valid_i && !reject;
    wr_map_o           = (cfg_action_i == ACT_MAP);
    wr_pe_o            = cfg_pe_i[PE_W-1:0];
    wr_slot_o.vld      = 1'b1;
    wr_slot_o.bus      = cfg_rid_i[15:8];
    wr_slot_o.dev      = cfg_rid_i[7:3];
    wr_slot_o.fn       = cfg_rid_i[2:0];
    wr_slot_o.bus_code = cfg_bus_code_i;
    wr_slot_o.dev_en   = cfg_dev_en_i;
    wr_slot_o.fn_en    = cfg_fn_en_i;
  end

  always_comb err_d = cfg_valid_i && reject;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_d;
  end

  assign err_o = err_q;

  a_r8_bad_action_err: assert property (@(posedge clk) disable iff (!rst_ni)
    (cfg_valid_i && cfg_action_i[1]) |=> err_o);

  a_r9_pe_range_err: assert property (@(posedge clk) disable iff (!rst_ni)
    (cfg_valid_i && (cfg_pe_i >= PE_IN_W'(NUM_PE))) |=> err_o);

  a_r9_code_one_err: assert property (@(posedge clk) disable iff (!rst_ni)
    (cfg_valid_i && (cfg_bus_code_i == 3'd1)) |=> err_o);

  a_r9_no_err_idle: assert property (@(posedge clk) disable iff (!rst_ni)
    !cfg_valid_i |=> !err_o);

endmodule

// File: rtl/rid_map_table.sv
module rid_map_table
  import rid_map_pkg::*;
#(
  parameter int NUM_PE = 12,
  parameter int PE_W   = $clog2(NUM_PE)
) (
  input  logic                   clk,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic                   wr_map_i,
  input  logic [PE_W-1:0]        wr_pe_i,
  input  rid_slot_t              wr_slot_i,
  output rid_slot_t [NUM_PE-1:0] slots_o
);

  rid_slot_t [NUM_PE-1:0] slot_q;

  for (genvar g = 0; g < NUM_PE; g++) begin : g_slot
    logic      ld_en;
    rid_slot_t slot_d;

    always_comb begin
      ld_en  = wr_en_i && (wr_pe_i == PE_W'(g));
      slot_d = slot_q[g];
      if (wr_map_i) slot_d = wr_slot_i;
      else          slot_d.vld = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)    slot_q[g] <= '0;
      else if (ld_en) slot_q[g] <= slot_d;
    end

    a_r8_untouched_holds: assert property (@(posedge clk) disable iff (!rst_ni)
      !(wr_en_i && (wr_pe_i == PE_W'(g))) |=> $stable(slot_q[g]));
  end

  assign slots_o = slot_q;

  a_r8_map_sets_valid: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en_i && wr_map_i) |=> slot_q[$past(wr_pe_i)].vld);

  a_r8_unmap_clears_valid: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en_i && !wr_map_i) |=> !slot_q[$past(wr_pe_i)].vld);

endmodule

// File: rtl/rid_map_match.sv
module rid_map_match
  import rid_map_pkg::*;
#(
  parameter int NUM_PE = 12,
  parameter int PE_W   = $clog2(NUM_PE)
) (
  input  logic                   clk,
  input  logic                   rst_ni,
  input  rid_slot_t [NUM_PE-1:0] slots_i,
  input  logic                   lk_valid_i,
  input  logic [RID_W-1:0]       lk_rid_i,
  output logic                   lk_valid_o,
  output logic                   lk_hit_o,
  output logic [PE_W-1:0]        lk_pe_o
);

  logic [7:0]        q_bus;
  logic [4:0]        q_dev;
  logic [2:0]        q_fn;
  logic [NUM_PE-1:0] hit_vec;

  assign q_bus = lk_rid_i[15:8];
  assign q_dev = lk_rid_i[7:3];
  assign q_fn  = lk_rid_i[2:0];

  for (genvar g = 0; g < NUM_PE; g++) begin : g_cmp
    logic bus_ok, dev_ok, fn_ok;
    always_comb begin
      bus_ok     = ((q_bus ^ slots_i[g].bus) & bus_mask(slots_i[g].bus_code)) == 8'h00;
      dev_ok     = !slots_i[g].dev_en || (q_dev == slots_i[g].dev);
      fn_ok      = !slots_i[g].fn_en  || (q_fn  == slots_i[g].fn);
      hit_vec[g] = slots_i[g].vld && bus_ok && dev_ok && fn_ok;
    end
  end

  // Lowest index wins: scan from the top so the last hit written is the lowest.
  logic            any_d;
  logic [PE_W-1:0] pe_d;
  always_comb begin
    any_d = 1'b0;
    pe_d  = '0;
    for (int i = NUM_PE - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_d = 1'b1;
        pe_d  = PE_W'(i);
      end
    end
  end

  logic            vld_q, hit_q;
  logic [PE_W-1:0] pe_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= lk_valid_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= 1'b0;
      pe_q  <= '0;
    end else if (lk_valid_i) begin
      hit_q <= any_d;
      pe_q  <= pe_d;
    end
  end

  assign lk_valid_o = vld_q;
  assign lk_hit_o   = hit_q;
  assign lk_pe_o    = pe_q;

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_ni)
    lk_valid_i |=> lk_valid_o);

  a_r11_idle_follows: assert property (@(posedge clk) disable iff (!rst_ni)
    !lk_valid_i |=> !lk_valid_o);

  a_r10_hit_matches_vector: assert property (@(posedge clk) disable iff (!rst_ni)
    lk_valid_i |=> (lk_hit_o == $past(|hit_vec)));

  a_r10_reported_pe_hits: assert property (@(posedge clk) disable iff (!rst_ni)
    lk_valid_i |=> (!lk_hit_o || $past(hit_vec[pe_d])));

  a_r10_miss_pe_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    (lk_valid_o && !lk_hit_o) |-> (lk_pe_o == '0));

endmodule

// File: rtl/rid_pe_mapper.sv
module rid_pe_mapper
  import rid_map_pkg::*;
#(
  parameter int NUM_PE  = 12,
  parameter int PE_IN_W = 8,
  parameter int PE_W    = $clog2(NUM_PE)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_valid_i,
  input  logic [PE_IN_W-1:0] cfg_pe_i,
  input  logic [15:0]        cfg_rid_i,
  input  logic [2:0]         cfg_bus_code_i,
  input  logic               cfg_dev_en_i,
  input  logic               cfg_fn_en_i,
  input  logic [1:0]         cfg_action_i,
  output logic               cfg_err_o,
  input  logic               lk_valid_i,
  input  logic [15:0]        lk_rid_i,
  output logic               lk_valid_o,
  output logic               lk_hit_o,
  output logic [PE_W-1:0]    lk_pe_o
);

  // Reset asserts at once and lifts two edges after rst_n rises.
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic                   wr_en, wr_map;
  logic [PE_W-1:0]        wr_pe;
  rid_slot_t              wr_slot;
  rid_slot_t [NUM_PE-1:0] slots;

  rid_map_cfg #(.NUM_PE(NUM_PE), .PE_IN_W(PE_IN_W), .PE_W(PE_W)) cfg_i (
    .clk            (clk),
    .rst_ni         (rst_ni),
    .cfg_valid_i    (cfg_valid_i),
    .cfg_pe_i       (cfg_pe_i),
    .cfg_rid_i      (cfg_rid_i),
    .cfg_bus_code_i (cfg_bus_code_i),
    .cfg_dev_en_i   (cfg_dev_en_i),
    .cfg_fn_en_i    (cfg_fn_en_i),
    .cfg_action_i   (cfg_action_i),
    .wr_en_o        (wr_en),
    .wr_map_o       (wr_map),
    .wr_pe_o        (wr_pe),
    .wr_slot_o      (wr_slot),
    .err_o          (cfg_err_o)
  );

  rid_map_table #(.NUM_PE(NUM_PE), .PE_W(PE_W)) table_i (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_map_i  (wr_map),
    .wr_pe_i   (wr_pe),
    .wr_slot_i (wr_slot),
    .slots_o   (slots)
  );

  rid_map_match #(.NUM_PE(NUM_PE), .PE_W(PE_W)) match_i (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .slots_i    (slots),
    .lk_valid_i (lk_valid_i),
    .lk_rid_i   (lk_rid_i),
    .lk_valid_o (lk_valid_o),
    .lk_hit_o   (lk_hit_o),
    .lk_pe_o    (lk_pe_o)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!lk_valid_o && !lk_hit_o && !cfg_err_o));

endmodule

// File: tb/rid_pe_mapper_tb_top.sv
module rid_pe_mapper_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_PE     = 12;
  localparam int PE_IN_W    = 8;
  localparam int PE_W       = 4;
  localparam int NVEC       = 16;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               cfg_valid_i;
  logic [PE_IN_W-1:0] cfg_pe_i;
  logic [15:0]        cfg_rid_i;
  logic [2:0]         cfg_bus_code_i;
  logic               cfg_dev_en_i;
  logic               cfg_fn_en_i;
  logic [1:0]         cfg_action_i;
  logic               cfg_err_o;
  logic               lk_valid_i;
  logic [15:0]        lk_rid_i;
  logic               lk_valid_o;
  logic               lk_hit_o;
  logic [PE_W-1:0]    lk_pe_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rid_pe_mapper #(.NUM_PE(NUM_PE), .PE_IN_W(PE_IN_W), .PE_W(PE_W)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_valid_i    (cfg_valid_i),
    .cfg_pe_i       (cfg_pe_i),
    .cfg_rid_i      (cfg_rid_i),
    .cfg_bus_code_i (cfg_bus_code_i),
    .cfg_dev_en_i   (cfg_dev_en_i),
    .cfg_fn_en_i    (cfg_fn_en_i),
    .cfg_action_i   (cfg_action_i),
    .cfg_err_o      (cfg_err_o),
    .lk_valid_i     (lk_valid_i),
    .lk_rid_i       (lk_rid_i),
    .lk_valid_o     (lk_valid_o),
    .lk_hit_o       (lk_hit_o),
    .lk_pe_o        (lk_pe_o)
  );

  // Lookup vectors {rid, expected hit, expected PE}, run against the base map:
  // PE3 0x402A code7 dev+fn; PE5 0xA000 code2; PE7 dev 9 code0 dev only;
  // PE9 0x6014 code6 fn only.
  localparam logic [24:0] VEC [NVEC] = '{
    {16'h402A, 1'b1, 8'd3},  // R2 R5 exact match
    {16'h412A, 1'b0, 8'd0},  // R5 one bus bit off
    {16'h402B, 1'b0, 8'd0},  // R7 function differs
    {16'h4032, 1'b0, 8'd0},  // R6 device differs
    {16'hA000, 1'b1, 8'd5},  // R4 bottom of 3-bit range
    {16'hBFFF, 1'b1, 8'd5},  // R4 top of 3-bit range
    {16'hC000, 1'b0, 8'd0},  // R4 just above range
    {16'h9F00, 1'b0, 8'd0},  // R4 just below range
    {16'h0048, 1'b1, 8'd7},  // R3 any bus, device 9
    {16'hFF4F, 1'b1, 8'd7},  // R3 R7 function ignored
    {16'h6014, 1'b1, 8'd9},  // R4 code 6 base
    {16'h61FC, 1'b1, 8'd9},  // R4 R6 low bus bit and device ignored
    {16'h6214, 1'b0, 8'd0},  // R4 bit 1 of bus compared
    {16'h6015, 1'b0, 8'd0},  // R7 function enforced
    {16'hA048, 1'b1, 8'd5},  // R10 PE5 and PE7 both match
    {16'h6048, 1'b1, 8'd7}   // R10 only PE7 matches
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] pe, input logic [15:0] rid,
                           input logic [2:0] code, input logic den,
                           input logic fen, input logic [1:0] act);
    @(negedge clk);
    cfg_valid_i    = 1'b1;
    cfg_pe_i       = pe;
    cfg_rid_i      = rid;
    cfg_bus_code_i = code;
    cfg_dev_en_i   = den;
    cfg_fn_en_i    = fen;
    cfg_action_i   = act;
    @(negedge clk);
    cfg_valid_i    = 1'b0;
    cfg_pe_i       = '0;
    cfg_rid_i      = '0;
    cfg_bus_code_i = '0;
    cfg_dev_en_i   = 1'b0;
    cfg_fn_en_i    = 1'b0;
    cfg_action_i   = '0;
  endtask

  task automatic lookup(input logic [15:0] rid, input string req,
                        input logic exp_hit, input logic [PE_W-1:0] exp_pe);
    @(negedge clk);
    lk_valid_i = 1'b1;
    lk_rid_i   = rid;
    @(negedge clk);
    lk_valid_i = 1'b0;
    lk_rid_i   = '0;
    check(req, "lookup valid", 32'(lk_valid_o), 32'd1);
    check(req, $sformatf("hit for %h", rid), 32'(lk_hit_o), 32'(exp_hit));
    check(req, $sformatf("pe for %h", rid), 32'(lk_pe_o), 32'(exp_pe));
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL R11 watchdog actual=timeout expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_valid_i = 1'b0; cfg_pe_i = '0; cfg_rid_i = '0; cfg_bus_code_i = '0;
    cfg_dev_en_i = 1'b0; cfg_fn_en_i = 1'b0; cfg_action_i = '0;
    lk_valid_i = 1'b0; lk_rid_i = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1", "lk_valid_o", 32'(lk_valid_o), 32'd0);
    check("R1", "lk_hit_o", 32'(lk_hit_o), 32'd0);
    check("R1", "cfg_err_o", 32'(cfg_err_o), 32'd0);
    lookup(16'h0000, "R1", 1'b0, 4'd0);
    lookup(16'hFFFF, "R1", 1'b0, 4'd0);

    // R9: refused writes
    cfg_write(8'd12, 16'h1234, 3'd7, 1'b1, 1'b1, 2'd1);
    check("R9", "err pe out of range", 32'(cfg_err_o), 32'd1);
    cfg_write(8'd2, 16'h1234, 3'd1, 1'b1, 1'b1, 2'd1);
    check("R9", "err bus code 1", 32'(cfg_err_o), 32'd1);
    // R8: refused action
    cfg_write(8'd2, 16'h1234, 3'd7, 1'b1, 1'b1, 2'd2);
    check("R8", "err action 2", 32'(cfg_err_o), 32'd1);
    cfg_write(8'd2, 16'h1234, 3'd7, 1'b1, 1'b1, 2'd3);
    check("R8", "err action 3", 32'(cfg_err_o), 32'd1);
    lookup(16'h1234, "R9", 1'b0, 4'd0);

    // Base map, each accepted (R9 no error)
    cfg_write(8'd3, 16'h402A, 3'd7, 1'b1, 1'b1, 2'd1);
    check("R9", "no err good write", 32'(cfg_err_o), 32'd0);
    cfg_write(8'd5, 16'hA000, 3'd2, 1'b0, 1'b0, 2'd1);
    cfg_write(8'd7, 16'h0048, 3'd0, 1'b1, 1'b0, 2'd1);
    cfg_write(8'd9, 16'h6014, 3'd6, 1'b0, 1'b1, 2'd1);
    check("R9", "no err last write", 32'(cfg_err_o), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      lookup(VEC[i][24:9], $sformatf("R2-table vec%0d", i), VEC[i][8], VEC[i][PE_W-1:0]);
    end

    // R8: unmap PE5, range disappears, priority falls to PE7
    cfg_write(8'd5, 16'h0000, 3'd0, 1'b0, 1'b0, 2'd0);
    check("R8", "no err unmap", 32'(cfg_err_o), 32'd0);
    lookup(16'hA000, "R8", 1'b0, 4'd0);
    lookup(16'hA048, "R10", 1'b1, 4'd7);

    // R10: catch-all at PE11 loses to lower slots
    cfg_write(8'd11, 16'h0000, 3'd0, 1'b0, 1'b0, 2'd1);
    lookup(16'h9F00, "R10", 1'b1, 4'd11);
    lookup(16'h402A, "R10", 1'b1, 4'd3);
    cfg_write(8'd0, 16'h0000, 3'd0, 1'b0, 1'b0, 2'd1);
    lookup(16'h402A, "R10", 1'b1, 4'd0);

    // R11: lookup issued with a write sees the old table
    @(negedge clk);
    cfg_valid_i = 1'b1; cfg_pe_i = 8'd0; cfg_action_i = 2'd0;
    lk_valid_i = 1'b1; lk_rid_i = 16'h9F00;
    @(negedge clk);
    cfg_valid_i = 1'b0; lk_valid_i = 1'b0; lk_rid_i = '0;
    check("R11", "old table pe", 32'(lk_pe_o), 32'd0);
    check("R11", "valid one cycle later", 32'(lk_valid_o), 32'd1);
    @(negedge clk);
    check("R11", "valid drops", 32'(lk_valid_o), 32'd0);
    lookup(16'h9F00, "R11", 1'b1, 4'd11);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule